// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This unit turns a base register value and an offset into the effective address of a load or store. It also produces the new base value when the instruction updates its base register. The offset is one of four things: nothing, a short 5-bit unsigned constant, a register value, or a long 15-bit unsigned constant. The long constant is legal only on two dedicated base registers. The offset is scaled by the access size, and it is then either added to or subtracted from the base.

An instruction can leave the base untouched or it can update it. When the update comes before the access (pre-modify), the new base is also the address. When the update comes after the access (post-modify), the old base is the address and the new base goes back to the register file. The result appears one clock after the request. The unit holds no memory and no register file. It reports an illegal combination instead of producing a writeback.

Top module: `lsAddrGen`

## Requirements
- R1: While `rstN` is low, `outValid`, `wbEn` and `illegalMode` are 0, and `effAddr` and `wbValue` are 0.
- R2: The outputs are registered with one cycle of latency: `outValid` equals the `inValid` of the previous cycle. After a cycle with `inValid` low, `wbEn` and `illegalMode` are 0, and `effAddr` and `wbValue` keep their values.
- R3: Plain form: `offSrc`=0 (none) with `modify`=0 (none) gives `effAddr` = base and `wbEn`=0.
- R4: The offset is shifted left by `accSize`: 0 is byte (x1), 1 is halfword (x2), 2 is word (x4), and 3 is treated as word.
- R5: With `modify`=0, `offSrc`=1 (short constant, `constField[4:0]` zero-extended) or `offSrc`=2 (`offsetValue`) gives `effAddr` = base + scaled offset, or base - scaled offset when `subtract`=1, and `wbEn`=0.
- R6: With `modify`=1 (pre), `effAddr` and `wbValue` both equal base ± scaled offset, and `wbEn`=1.
- R7: With `modify`=2 (post), `effAddr` = base, `wbValue` = base ± scaled offset, and `wbEn`=1.
- R8: `offSrc`=0 together with a pre or post modify uses an offset of 1, scaled by the access size.
- R9: `offSrc`=3 (long constant, `constField[14:0]` zero-extended) is legal when `baseBankB`=1, `baseIndex` is 14 or 15, `subtract`=0 and `modify`=0. It gives `effAddr` = base + scaled constant and `wbEn`=0.
- R10: Any other use of `offSrc`=3, and any request with `modify`=3, sets `illegalMode`=1 with `wbEn`=0 and `effAddr` = base.
- R11: All sums and differences wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request valid |
| baseValue | input | 32 | Current base register value |
| baseBankB | input | 1 | Base register is in the B bank |
| baseIndex | input | 5 | Base register number within its bank |
| offsetValue | input | 32 | Offset register value |
| constField | input | 15 | Constant offset field (low 5 bits for short form) |
| offSrc | input | 2 | Offset source: 0 none, 1 short const, 2 register, 3 long const |
| subtract | input | 1 | Subtract the offset instead of adding it |
| modify | input | 2 | Base update: 0 none, 1 pre, 2 post, 3 reserved |
| accSize | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 word |
| outValid | output | 1 | Result valid |
| effAddr | output | 32 | Effective address |
| wbEn | output | 1 | Base register writeback enable |
| wbValue | output | 32 | Updated base value |
| illegalMode | output | 1 | Illegal long-offset or reserved modify request |

## Verification
Random requests sweep every combination of offset source, direction, modify form and access size, with random bases and offsets. These cases show whether the scaling, the sign and the choice of old or new base are routed correctly in each form. Long-constant requests are biased toward base indexes 14 and 15 in both banks, so that the legal case and its illegal neighbours both occur often. Directed cases push the sums across zero and across the top of the address space, which separates correct wraparound from an off-by-one or a dropped carry.

// File: rtl/lsAddrGenPkg.sv
package lsAddrGenPkg;
  typedef enum logic [1:0] {OFF_NONE = 2'd0, OFF_SHORT = 2'd1, OFF_REG = 2'd2, OFF_LONG = 2'd3} offSrc_e;
  typedef enum logic [1:0] {MOD_NONE = 2'd0, MOD_PRE = 2'd1, MOD_POST = 2'd2, MOD_RSVD = 2'd3} modify_e;

  typedef struct packed {
    logic       selOne;
    logic       selShort;
    logic       selReg;
    logic       selLong;
    logic       doSub;
    logic       doWb;
    logic       useOldBase;
    logic       illegal;
    logic [1:0] shiftAmt;
  } agStrobe_t;
endpackage

// File: rtl/lsAddrGenCtrl.sv
module lsAddrGenCtrl
  import lsAddrGenPkg::*;
#(
  parameter int IDX_W = 5,
  parameter int LONG_IDX_LO = 14,
  parameter int LONG_IDX_HI = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             baseBankB,
  input  logic [IDX_W-1:0] baseIndex,
  input  logic [1:0]       offSrc,
  input  logic             subtract,
  input  logic [1:0]       modify,
  input  logic [1:0]       accSize,
  output agStrobe_t        strobe
);
  logic longBase;
  logic longOk;
  logic rsvdMod;
  logic badReq;

  assign longBase = baseBankB &&
                    ((baseIndex == IDX_W'(LONG_IDX_LO)) || (baseIndex == IDX_W'(LONG_IDX_HI)));
  assign longOk   = longBase && !subtract && (modify == MOD_NONE);
  assign rsvdMod  = (modify == MOD_RSVD);
  assign badReq   = rsvdMod || ((offSrc == OFF_LONG) && !longOk);

  always_comb begin
    strobe            = '0;
    strobe.illegal    = badReq;
    strobe.shiftAmt   = (accSize == 2'd3) ? 2'd2 : accSize;
    if (!badReq) begin
      strobe.doSub      = subtract;
      strobe.doWb       = (modify == MOD_PRE) || (modify == MOD_POST);
      strobe.useOldBase = (modify == MOD_POST);
      unique case (offSrc)
        OFF_NONE:  strobe.selOne   = (modify != MOD_NONE);
        OFF_SHORT: strobe.selShort = 1'b1;
        OFF_REG:   strobe.selReg   = 1'b1;
        default:   strobe.selLong  = 1'b1;
      endcase
    end
  end

  assert_long_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.selLong |-> (longBase && !subtract && !strobe.doWb));

  assert_illegal_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.illegal |-> !(strobe.doWb || strobe.selOne || strobe.selShort || strobe.selReg || strobe.selLong));
endmodule

// File: rtl/lsAddrGenDatapath.sv
module lsAddrGenDatapath
  import lsAddrGenPkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SHORT_W = 5,
  parameter int LONG_W  = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [ADDR_W-1:0] baseValue,
  input  logic [ADDR_W-1:0] offsetValue,
  input  logic [LONG_W-1:0] constField,
  input  agStrobe_t         strobe,
  output logic              outValid,
  output logic [ADDR_W-1:0] effAddr,
  output logic              wbEn,
  output logic [ADDR_W-1:0] wbValue,
  output logic              illegalMode
);
  logic [ADDR_W-1:0] rawOff;
  logic [ADDR_W-1:0] scaledOff;
  logic [ADDR_W-1:0] newBase;
  logic [ADDR_W-1:0] addrNext;

  always_comb begin
    rawOff = '0;
    if (strobe.selOne)   rawOff = ADDR_W'(1);
    if (strobe.selShort) rawOff = ADDR_W'(constField[SHORT_W-1:0]);
    if (strobe.selReg)   rawOff = offsetValue;
    if (strobe.selLong)  rawOff = ADDR_W'(constField);
    scaledOff = rawOff << strobe.shiftAmt;
    newBase   = strobe.doSub ? (baseValue - scaledOff) : (baseValue + scaledOff);
    addrNext  = strobe.useOldBase ? baseValue : newBase;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      wbEn        <= 1'b0;
      illegalMode <= 1'b0;
      effAddr     <= '0;
      wbValue     <= '0;
    end else begin
      outValid    <= inValid;
      wbEn        <= inValid && strobe.doWb;
      illegalMode <= inValid && strobe.illegal;
      if (inValid) begin
        effAddr <= addrNext;
        wbValue <= newBase;
      end
    end
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (outValid == $past(inValid)));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (!wbEn && !illegalMode));

  assert_post_old_base_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && strobe.useOldBase) |=> (effAddr == $past(baseValue)));

  assert_illegal_no_wb_R10: assert property (@(posedge clk) disable iff (!rstN)
    illegalMode |-> (!wbEn && outValid));
endmodule

// File: rtl/lsAddrGen.sv
module lsAddrGen
  import lsAddrGenPkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 5,
  parameter int SHORT_W     = 5,
  parameter int LONG_W      = 15,
  parameter int LONG_IDX_LO = 14,
  parameter int LONG_IDX_HI = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [ADDR_W-1:0] baseValue,
  input  logic              baseBankB,
  input  logic [IDX_W-1:0]  baseIndex,
  input  logic [ADDR_W-1:0] offsetValue,
  input  logic [LONG_W-1:0] constField,
  input  logic [1:0]        offSrc,
  input  logic              subtract,
  input  logic [1:0]        modify,
  input  logic [1:0]        accSize,
  output logic              outValid,
  output logic [ADDR_W-1:0] effAddr,
  output logic              wbEn,
  output logic [ADDR_W-1:0] wbValue,
  output logic              illegalMode
);
  agStrobe_t strobe;

  lsAddrGenCtrl #(
    .IDX_W(IDX_W), .LONG_IDX_LO(LONG_IDX_LO), .LONG_IDX_HI(LONG_IDX_HI)
  ) ctrl (
    .clk(clk), .rstN(rstN), .baseBankB(baseBankB), .baseIndex(baseIndex),
    .offSrc(offSrc), .subtract(subtract), .modify(modify), .accSize(accSize),
    .strobe(strobe)
  );

  lsAddrGenDatapath #(
    .ADDR_W(ADDR_W), .SHORT_W(SHORT_W), .LONG_W(LONG_W)
  ) dp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .baseValue(baseValue),
    .offsetValue(offsetValue), .constField(constField), .strobe(strobe),
    .outValid(outValid), .effAddr(effAddr), .wbEn(wbEn), .wbValue(wbValue),
    .illegalMode(illegalMode)
  );
endmodule

// File: tb/lsAddrGen_test.sv
module lsAddrGen_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] baseValue = '0;
  logic        baseBankB = 1'b0;
  logic [4:0]  baseIndex = '0;
  logic [31:0] offsetValue = '0;
  logic [14:0] constField = '0;
  logic [1:0]  offSrc = '0;
  logic        subtract = 1'b0;
  logic [1:0]  modify = '0;
  logic [1:0]  accSize = '0;
  logic        outValid, wbEn, illegalMode;
  logic [31:0] effAddr, wbValue;

  int vectors = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [31:0] expAddr = '0;
  logic [31:0] expWb = '0;
  logic expWbEn, expIll;

  always #5 clk = ~clk;

  lsAddrGen uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .baseValue(baseValue),
    .baseBankB(baseBankB), .baseIndex(baseIndex), .offsetValue(offsetValue),
    .constField(constField), .offSrc(offSrc), .subtract(subtract), .modify(modify),
    .accSize(accSize), .outValid(outValid), .effAddr(effAddr), .wbEn(wbEn),
    .wbValue(wbValue), .illegalMode(illegalMode)
  );

  function automatic string tagOf();
    if (modify == 2'd3) return "R10";
    if (offSrc == 2'd3)
      return (baseBankB && (baseIndex == 5'd14 || baseIndex == 5'd15) && !subtract && modify == 2'd0) ? "R9" : "R10";
    if (modify == 2'd1) return (offSrc == 2'd0) ? "R8/R6" : "R6";
    if (modify == 2'd2) return (offSrc == 2'd0) ? "R8/R7" : "R7";
    return (offSrc == 2'd0) ? "R3" : "R5/R4/R11";
  endfunction

  task automatic model();
    logic [31:0] off;
    logic [31:0] nb;
    int sh;
    bit ill;
    sh = (accSize == 2'd3) ? 2 : int'(accSize);
    ill = (modify == 2'd3) ||
          (offSrc == 2'd3 && !(baseBankB && (baseIndex == 5'd14 || baseIndex == 5'd15) && !subtract && modify == 2'd0));
    case (offSrc)
      2'd0: off = (modify == 2'd0) ? 32'd0 : 32'd1;
      2'd1: off = {27'd0, constField[4:0]};
      2'd2: off = offsetValue;
      default: off = {17'd0, constField};
    endcase
    off = off << sh;
    nb = subtract ? baseValue - off : baseValue + off;
    expIll = ill;
    if (ill) begin
      expWbEn = 1'b0; expAddr = baseValue; expWb = baseValue;
    end else begin
      expWbEn = (modify == 2'd1) || (modify == 2'd2);
      expAddr = (modify == 2'd2) ? baseValue : nb;
      expWb = nb;
    end
  endtask

  task automatic step(bit v);
    string tag;
    inValid = v;
    tag = v ? tagOf() : "R2";
    if (v) model();
    else begin expWbEn = 1'b0; expIll = 1'b0; end
    @(negedge clk);
    vectors++;
    if (outValid !== v || effAddr !== expAddr || wbEn !== expWbEn || illegalMode !== expIll ||
        (expWbEn && wbValue !== expWb) || (!v && wbValue !== expWb)) begin
      fails++;
      $display("FAIL %s: got v=%0b a=%h we=%0b wb=%h il=%0b exp v=%0b a=%h we=%0b wb=%h il=%0b",
               tag, outValid, effAddr, wbEn, wbValue, illegalMode,
               v, expAddr, expWbEn, expWb, expIll);
    end
  endtask

  task automatic setReq(logic [31:0] b, logic bk, logic [4:0] ix, logic [31:0] o,
                        logic [14:0] c, logic [1:0] src, logic sb, logic [1:0] md, logic [1:0] sz);
    baseValue = b; baseBankB = bk; baseIndex = ix; offsetValue = o; constField = c;
    offSrc = src; subtract = sb; modify = md; accSize = sz;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    inValid = 1'b1;
    setReq(32'h1234_5678, 1'b1, 5'd15, 32'd9, 15'h7fff, 2'd1, 1'b0, 2'd1, 2'd2);
    repeat (3) @(negedge clk);
    vectors++;
    if (outValid !== 1'b0 || wbEn !== 1'b0 || illegalMode !== 1'b0 || effAddr !== 32'd0 || wbValue !== 32'd0) begin
      fails++;
      $display("FAIL R1: got v=%0b a=%h we=%0b wb=%h il=%0b exp all zero", outValid, effAddr, wbEn, wbValue, illegalMode);
    end
    rstN = 1'b1;
    // R3 plain
    setReq(32'hdead_beef, 1'b0, 5'd3, 32'd77, 15'd5, 2'd0, 1'b1, 2'd0, 2'd2); step(1);
    // R11 wrap up: short const 2 words on 0xFFFFFFFC
    setReq(32'hffff_fffc, 1'b0, 5'd1, 32'd0, 15'd2, 2'd1, 1'b0, 2'd0, 2'd2); step(1);
    // R11 wrap down with R8 post-decrement by one byte
    setReq(32'h0, 1'b1, 5'd2, 32'd0, 15'd0, 2'd0, 1'b1, 2'd2, 2'd0); step(1);
    // R8 pre-increment by one halfword
    setReq(32'h100, 1'b0, 5'd4, 32'd0, 15'd0, 2'd0, 1'b0, 2'd1, 2'd1); step(1);
    // R4 size 3 treated as word, register offset subtract
    setReq(32'h1000, 1'b0, 5'd4, 32'h10, 15'd0, 2'd2, 1'b1, 2'd0, 2'd3); step(1);
    // R9 long on B15 max constant, word
    setReq(32'h8000_0000, 1'b1, 5'd15, 32'd0, 15'h7fff, 2'd3, 1'b0, 2'd0, 2'd2); step(1);
    // R9 long on B14
    setReq(32'h40, 1'b1, 5'd14, 32'd0, 15'h0123, 2'd3, 1'b0, 2'd0, 2'd0); step(1);
    // R10 long on A15, on B13, with subtract, with post
    setReq(32'h40, 1'b0, 5'd15, 32'd0, 15'h0123, 2'd3, 1'b0, 2'd0, 2'd0); step(1);
    setReq(32'h40, 1'b1, 5'd13, 32'd0, 15'h0123, 2'd3, 1'b0, 2'd0, 2'd0); step(1);
    setReq(32'h40, 1'b1, 5'd15, 32'd0, 15'h0123, 2'd3, 1'b1, 2'd0, 2'd0); step(1);
    setReq(32'h40, 1'b1, 5'd14, 32'd0, 15'h0123, 2'd3, 1'b0, 2'd2, 2'd0); step(1);
    // R10 reserved modify
    setReq(32'h77, 1'b0, 5'd0, 32'd8, 15'd3, 2'd2, 1'b0, 2'd3, 2'd1); step(1);
    // R2 idle hold after a writeback
    setReq(32'h500, 1'b0, 5'd0, 32'd3, 15'd0, 2'd2, 1'b0, 2'd1, 2'd2); step(1);
    setReq(32'h9999, 1'b0, 5'd0, 32'd1, 15'd0, 2'd2, 1'b0, 2'd1, 2'd2); step(0);
    step(0);
    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] ix;
      ix = ($urandom_range(0, 1) == 0) ? 5'(14 + $urandom_range(0, 1)) : 5'($urandom);
      setReq($urandom, 1'($urandom), ix, $urandom, 15'($urandom), 2'($urandom),
             1'($urandom), ($urandom_range(0, 9) == 0) ? 2'd3 : 2'($urandom_range(0, 2)), 2'($urandom));
      step($urandom_range(0, 99) < 85);
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule